// File: doc/BRIEF.md
# Row-Cycle Timing Guard for One DRAM Bank Group

This block sits between a DRAM command scheduler and the command bus. It follows the row state (open or closed) of one bank group and decides each cycle whether the requested ACTIVATE, READ or PRECHARGE may go out now. A command is granted only when every spacing rule measured from the commands already granted has been met. A request that is not granted is simply not issued that cycle, and the scheduler may present it again later.

The programmed row-active time is not taken on trust. The block computes the shortest row-active time that can work, which is the activate-to-read delay plus the CAS latency plus the read-to-precharge delay. It then uses the larger of that value and the programmed one. For example, a programmed row-active time of 30 with 12 + 18 + 10 becomes 40. The activate-to-activate spacing gets the same treatment against a floor of 6 clocks. Whenever either value is raised, a sticky flag is set. Timing settings are copied into the block only while the row is closed, so an open-row window keeps the thresholds it started with.

Top module: `bank_timing_guard`

## Requirements
- R1: `eff_tras` equals the larger of the programmed row-active time and trcd + tcl + trtp, taken from the settings present during a cycle in which the row is closed. Programmed 30 with 12/18/10 gives 40.
- R2: `eff_trrd` equals the larger of the programmed activate spacing and 6.
- R3: `clamp_flag` is set after a row-closed cycle in which R1 or R2 raised a value. It is cleared by `clamp_clr` only in a cycle where no new raise occurs. Setting wins over clearing.
- R4: READ is granted only to an open row, and only when at least trcd cycles separate it from the ACTIVATE grant.
- R5: Two READ grants are at least 4 cycles apart (burst length).
- R6: PRECHARGE is granted only to an open row, only when at least `eff_tras` cycles have passed since the ACTIVATE, and only when at least trtp cycles have passed since the last READ. After it, the row is closed.
- R7: ACTIVATE is granted only to a closed row, and only when at least `eff_trrd` cycles have passed since the previous ACTIVATE. After it, the row is open.
- R8: An ACTIVATE to an open row is refused without an error. A READ or PRECHARGE to a closed row is refused, and `err_pulse` is high for exactly the next cycle.
- R9: A change to the settings while the row is open has no effect on `eff_tras`, `eff_trrd` or any threshold until the row is closed again.
- R10: When several requests are high together, PRECHARGE outranks READ, and READ outranks ACTIVATE. Only the highest-ranked request is considered, so at most one grant is high in any cycle.
- R11: Synchronous reset closes the row, clears `err_pulse` and `clamp_flag`, and sets `eff_tras` to 0 and `eff_trrd` to 6. The spacing counters start saturated, so the first ACTIVATE needs no wait.
- R12: The elapsed-cycle counters saturate and do not wrap. A PRECHARGE requested 1030 cycles after an ACTIVATE, with `eff_tras` = 710, is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_act | input | 1 | ACTIVATE request |
| req_rd | input | 1 | READ request |
| req_pre | input | 1 | PRECHARGE request |
| clamp_clr | input | 1 | Clears the sticky clamp flag |
| cfg_trcd | input | TW | Activate-to-read delay, in clocks |
| cfg_tcl | input | TW | CAS latency, in clocks |
| cfg_trtp | input | TW | Read-to-precharge delay, in clocks |
| cfg_tras | input | TW | Programmed row-active time, in clocks |
| cfg_trrd | input | TW | Programmed activate-to-activate spacing, in clocks |
| gnt_act | output | 1 | ACTIVATE granted this cycle |
| gnt_rd | output | 1 | READ granted this cycle |
| gnt_pre | output | 1 | PRECHARGE granted this cycle |
| err_pulse | output | 1 | One-cycle pulse after a READ or PRECHARGE to a closed row |
| eff_tras | output | TW+2 | Row-active time in use |
| eff_trrd | output | TW | Activate spacing in use |
| clamp_flag | output | 1 | Sticky: a programmed value was raised |

## Verification
The assertions assume that a grant is acted on in the cycle it appears, and that the requests are sampled only at the clock edge. The bench therefore changes requests and settings only at the falling edge, and only through a single driver task. The settings are treated as quasi-static: the bench changes them at chosen points, including while a row is open, so that the rule that settings are copied only while the row is closed is exercised on purpose. Request patterns include repeated requests that are held until granted, requests to a row in the wrong state, and all three requests at once.

// File: rtl/btg_pkg.sv
`timescale 1ns/1ps
package btg_pkg;
  localparam int FW = 16;
  typedef logic [FW-1:0] fword_t;

  typedef enum logic {ROW_CLOSED = 1'b0, ROW_OPEN = 1'b1} row_state_e;

  // shortest legal row-active time
  function automatic fword_t row_floor(fword_t rcd, fword_t cl, fword_t rtp);
    return rcd + cl + rtp;
  endfunction

  // raise a programmed value to a floor
  function automatic fword_t lift(fword_t val, fword_t floor_v);
    return (val < floor_v) ? floor_v : val;
  endfunction

  // elapsed cycles satisfy a requirement
  function automatic logic reached(fword_t elapsed, fword_t need);
    return elapsed >= need;
  endfunction
endpackage

// File: rtl/btg_sat_cnt.sv
`timescale 1ns/1ps
module btg_sat_cnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          preset,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= TOP;
    else if (restart)     cnt <= ONE;
    else if (preset)      cnt <= TOP;
    else if (cnt != TOP)  cnt <= cnt + ONE;
  end

  // R12: a saturated counter stays saturated until restarted
  p_sat_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP && !restart && !preset) |=> cnt == TOP);

  // R12: below saturation the counter advances by exactly one
  p_step_r12: assert property (@(posedge clk) disable iff (rst)
    (cnt != TOP && !restart && !preset) |=> cnt == $past(cnt) + ONE);
endmodule

// File: rtl/btg_cfg_latch.sv
`timescale 1ns/1ps
module btg_cfg_latch
  import btg_pkg::*;
#(
  parameter int TW      = 8,
  parameter int MIN_RRD = 6,
  localparam int CW     = TW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clr,
  input  logic [TW-1:0] cfg_trcd,
  input  logic [TW-1:0] cfg_tcl,
  input  logic [TW-1:0] cfg_trtp,
  input  logic [TW-1:0] cfg_tras,
  input  logic [TW-1:0] cfg_trrd,
  output logic [TW-1:0] trcd_q,
  output logic [TW-1:0] trtp_q,
  output logic [CW-1:0] tras_q,
  output logic [TW-1:0] trrd_q,
  output logic          clamp_flag
);
  logic [CW-1:0] tras_d;
  logic [TW-1:0] trrd_d;
  logic          raise_now;
  logic          clamp_hit;   // event wire: a raise is being captured

  always_comb begin
    tras_d    = CW'(lift(fword_t'(cfg_tras),
                         row_floor(fword_t'(cfg_trcd), fword_t'(cfg_tcl), fword_t'(cfg_trtp))));
    trrd_d    = TW'(lift(fword_t'(cfg_trrd), fword_t'(MIN_RRD)));
    raise_now = (tras_d != CW'(cfg_tras)) || (trrd_d != cfg_trrd);
    clamp_hit = load && raise_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trcd_q <= '0;
      trtp_q <= '0;
      tras_q <= '0;
      trrd_q <= TW'(MIN_RRD);
    end else if (load) begin
      trcd_q <= cfg_trcd;
      trtp_q <= cfg_trtp;
      tras_q <= tras_d;
      trrd_q <= trrd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            clamp_flag <= 1'b0;
    else if (clamp_hit) clamp_flag <= 1'b1;
    else if (clr)       clamp_flag <= 1'b0;
  end

  // R9: thresholds frozen while not loading
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(tras_q) && $stable(trrd_q) && $stable(trcd_q) && $stable(trtp_q)));

  // R2: spacing in use never below the floor
  p_rrd_floor_r2: assert property (@(posedge clk) disable iff (rst)
    trrd_q >= TW'(MIN_RRD));

  // R3: a captured raise always leaves the flag set
  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    clamp_hit |=> clamp_flag);
endmodule

// File: rtl/bank_timing_guard.sv
`timescale 1ns/1ps
module bank_timing_guard
  import btg_pkg::*;
#(
  parameter int TW      = 8,
  parameter int MIN_RRD = 6,
  parameter int BURST   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_act,
  input  logic          req_rd,
  input  logic          req_pre,
  input  logic          clamp_clr,
  input  logic [TW-1:0] cfg_trcd,
  input  logic [TW-1:0] cfg_tcl,
  input  logic [TW-1:0] cfg_trtp,
  input  logic [TW-1:0] cfg_tras,
  input  logic [TW-1:0] cfg_trrd,
  output logic          gnt_act,
  output logic          gnt_rd,
  output logic          gnt_pre,
  output logic          err_pulse,
  output logic [TW+1:0] eff_tras,
  output logic [TW-1:0] eff_trrd,
  output logic          clamp_flag
);
  localparam int CW = TW + 2;

  row_state_e    row_q;
  logic          row_open;
  logic [TW-1:0] trcd_q, trtp_q;
  logic [CW-1:0] act_cnt, rd_cnt;

  // named events for the assertions
  logic sel_act, sel_rd, sel_pre;
  logic rcd_met, burst_met, ras_met, rtp_met, rrd_met;
  logic bad_cmd;

  assign row_open = (row_q == ROW_OPEN);

  btg_cfg_latch #(.TW(TW), .MIN_RRD(MIN_RRD)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load       (!row_open),
    .clr        (clamp_clr),
    .cfg_trcd   (cfg_trcd),
    .cfg_tcl    (cfg_tcl),
    .cfg_trtp   (cfg_trtp),
    .cfg_tras   (cfg_tras),
    .cfg_trrd   (cfg_trrd),
    .trcd_q     (trcd_q),
    .trtp_q     (trtp_q),
    .tras_q     (eff_tras),
    .trrd_q     (eff_trrd),
    .clamp_flag (clamp_flag)
  );

  btg_sat_cnt #(.CW(CW)) u_act_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (gnt_act),
    .preset  (1'b0),
    .cnt     (act_cnt)
  );

  btg_sat_cnt #(.CW(CW)) u_rd_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (gnt_rd),
    .preset  (gnt_act),
    .cnt     (rd_cnt)
  );

  always_comb begin
    sel_pre   = req_pre;
    sel_rd    = req_rd  && !req_pre;
    sel_act   = req_act && !req_pre && !req_rd;

    rcd_met   = reached(fword_t'(act_cnt), fword_t'(trcd_q));
    burst_met = reached(fword_t'(rd_cnt),  fword_t'(BURST));
    ras_met   = reached(fword_t'(act_cnt), fword_t'(eff_tras));
    rtp_met   = reached(fword_t'(rd_cnt),  fword_t'(trtp_q));
    rrd_met   = reached(fword_t'(act_cnt), fword_t'(eff_trrd));

    gnt_pre   = sel_pre && row_open && ras_met && rtp_met;
    gnt_rd    = sel_rd  && row_open && rcd_met && burst_met;
    gnt_act   = sel_act && !row_open && rrd_met;

    bad_cmd   = !row_open && (req_rd || req_pre);
  end

  always_ff @(posedge clk) begin
    if (rst)          row_q <= ROW_CLOSED;
    else if (gnt_act) row_q <= ROW_OPEN;
    else if (gnt_pre) row_q <= ROW_CLOSED;
  end

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= bad_cmd;
  end

  // R10: never more than one grant
  p_one_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_act, gnt_rd, gnt_pre}));

  // R7: an activate opens the row
  p_act_opens_r7: assert property (@(posedge clk) disable iff (rst)
    gnt_act |=> row_open);

  // R6: a precharge closes the row
  p_pre_closes_r6: assert property (@(posedge clk) disable iff (rst)
    gnt_pre |=> !row_open);

  // R8: a read to a closed row raises the error next cycle
  p_err_closed_r8: assert property (@(posedge clk) disable iff (rst)
    (req_rd && !row_open) |=> err_pulse);

  // R5: two reads are never in adjacent cycles
  p_rd_gap_r5: assert property (@(posedge clk) disable iff (rst)
    gnt_rd |=> !gnt_rd);

  // R4: a read never follows its activate in the next cycle when trcd > 1
  p_rcd_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt_act && trcd_q > TW'(1)) |=> !gnt_rd);

  // R11: reset leaves the row closed and no error
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!row_open && !err_pulse));
endmodule

// File: tb/bank_timing_guard_tb.sv
`timescale 1ns/1ps
module bank_timing_guard_tb;
  localparam int TW = 8;
  localparam int CW = TW + 2;
  localparam int FAR = -100000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_act = 0, req_rd = 0, req_pre = 0, clamp_clr = 0;
  logic [TW-1:0] cfg_trcd = 0, cfg_tcl = 0, cfg_trtp = 0, cfg_tras = 0, cfg_trrd = 0;
  logic          gnt_act, gnt_rd, gnt_pre, err_pulse, clamp_flag;
  logic [CW-1:0] eff_tras;
  logic [TW-1:0] eff_trrd;

  bank_timing_guard #(.TW(TW)) u_dut (
    .clk(clk), .rst(rst), .req_act(req_act), .req_rd(req_rd), .req_pre(req_pre),
    .clamp_clr(clamp_clr), .cfg_trcd(cfg_trcd), .cfg_tcl(cfg_tcl), .cfg_trtp(cfg_trtp),
    .cfg_tras(cfg_tras), .cfg_trrd(cfg_trrd), .gnt_act(gnt_act), .gnt_rd(gnt_rd),
    .gnt_pre(gnt_pre), .err_pulse(err_pulse), .eff_tras(eff_tras), .eff_trrd(eff_trrd),
    .clamp_flag(clamp_flag)
  );

  typedef struct {
    bit ga, gr, gp, er, fl;
    int tras, trrd;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int n_chk = 0, n_fail = 0;
  bit mon_ga, mon_gr, mon_gp, mon_er;

  // settings to drive at the next step
  int n_trcd, n_tcl, n_trtp, n_tras, n_trrd;
  // independent model
  int cyc = 0, act_cyc = FAR, rd_cyc = FAR;
  bit m_open = 0, m_prev_err = 0, m_flag = 0;
  int m_trcd = 0, m_trtp = 0, m_tras = 0, m_trrd = 6;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input bit a, input bit r, input bit p, input bit clr);
    exp_t e;
    int sum, nt, nr;
    bit ha, hr, hp, raised;
    @(negedge clk);
    rst = 1'b0;
    req_act = a; req_rd = r; req_pre = p; clamp_clr = clr;
    cfg_trcd = TW'(n_trcd); cfg_tcl = TW'(n_tcl); cfg_trtp = TW'(n_trtp);
    cfg_tras = TW'(n_tras); cfg_trrd = TW'(n_trrd);
    hp = p; hr = r && !p; ha = a && !p && !r;
    e.gp = hp && m_open && (cyc - act_cyc) >= m_tras && (cyc - rd_cyc) >= m_trtp;
    e.gr = hr && m_open && (cyc - act_cyc) >= m_trcd && (cyc - rd_cyc) >= 4;
    e.ga = ha && !m_open && (cyc - act_cyc) >= m_trrd;
    e.er = m_prev_err;
    e.fl = m_flag;
    e.tras = m_tras;
    e.trrd = m_trrd;
    sb.push_back(e);
    m_prev_err = !m_open && (r || p);
    if (!m_open) begin
      sum = n_trcd + n_tcl + n_trtp;
      nt = (n_tras < sum) ? sum : n_tras;
      nr = (n_trrd < 6) ? 6 : n_trrd;
      raised = (nt != n_tras) || (nr != n_trrd);
      m_trcd = n_trcd; m_trtp = n_trtp; m_tras = nt; m_trrd = nr;
      if (raised) m_flag = 1;
      else if (clr) m_flag = 0;
    end else if (clr) m_flag = 0;
    if (e.ga) begin m_open = 1; act_cyc = cyc; rd_cyc = FAR; end
    if (e.gr) rd_cyc = cyc;
    if (e.gp) m_open = 0;
    cyc++;
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic run_until(input bit a, input bit r, input bit p, input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      step(a, r, p, 0);
      if ((a && mon_ga) || (r && mon_gr) || (p && mon_gp)) begin
        at = cyc - 1;
        break;
      end
    end
  endtask

  // monitor: pops the scoreboard and compares every cycle
  initial forever begin
    @(negedge clk);
    #1;
    if (sb.size() > 0) begin
      mon_e = sb.pop_front();
      mon_ga = gnt_act; mon_gr = gnt_rd; mon_gp = gnt_pre; mon_er = err_pulse;
      chk("R7", "gnt_act", int'(gnt_act), int'(mon_e.ga));
      chk("R4", "gnt_rd", int'(gnt_rd), int'(mon_e.gr));
      chk("R6", "gnt_pre", int'(gnt_pre), int'(mon_e.gp));
      chk("R8", "err_pulse", int'(err_pulse), int'(mon_e.er));
      chk("R1", "eff_tras", int'(eff_tras), mon_e.tras);
      chk("R2", "eff_trrd", int'(eff_trrd), mon_e.trrd);
      chk("R3", "clamp_flag", int'(clamp_flag), int'(mon_e.fl));
    end
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t_a, t_r, t_x;
    n_trcd = 12; n_tcl = 18; n_trtp = 10; n_tras = 30; n_trrd = 2;
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk("R11", "gnt any", int'(gnt_act | gnt_rd | gnt_pre), 0);
    chk("R11", "err_pulse", int'(err_pulse), 0);
    chk("R11", "clamp_flag", int'(clamp_flag), 0);
    chk("R11", "eff_tras", int'(eff_tras), 0);
    chk("R11", "eff_trrd", int'(eff_trrd), 6);

    idle(2);
    chk("R1", "raised tras 30->40", int'(eff_tras), 40);
    chk("R2", "raised trrd 2->6", int'(eff_trrd), 6);
    chk("R3", "flag after raise", int'(clamp_flag), 1);

    step(1, 0, 0, 0);
    t_a = cyc - 1;
    chk("R11", "first act without wait", int'(mon_ga), 1);
    step(1, 0, 0, 0);
    chk("R8", "act to open row refused", int'(mon_ga), 0);

    run_until(0, 1, 0, 50, t_r);
    chk("R4", "read delay after act", t_r - t_a, 12);
    n_tras = 200; n_trrd = 3;          // changed while open
    run_until(0, 1, 0, 50, t_x);
    chk("R5", "read to read gap", t_x - t_r, 4);
    run_until(0, 0, 1, 80, t_x);
    chk("R6", "precharge after eff tras", t_x - t_a, 40);
    chk("R9", "eff_tras frozen while open", int'(eff_tras), 40);
    idle(2);

    // short thresholds, spacing floor
    n_trcd = 1; n_tcl = 1; n_trtp = 1; n_tras = 0; n_trrd = 2;
    idle(2);
    run_until(1, 0, 0, 20, t_a);
    run_until(0, 0, 1, 20, t_x);
    chk("R6", "precharge at tras 3", t_x - t_a, 3);
    run_until(1, 0, 0, 20, t_x);
    chk("R7", "act spacing floor 6", t_x - t_a, 6);
    t_a = t_x;
    n_trrd = 9;
    run_until(0, 0, 1, 20, t_x);
    run_until(1, 0, 0, 30, t_x);
    chk("R7", "act spacing 9", t_x - t_a, 9);

    // priority
    idle(3);
    step(1, 1, 1, 0);
    chk("R10", "pre wins", int'(mon_gp), 1);
    chk("R10", "read not granted", int'(mon_gr), 0);
    chk("R10", "act not granted", int'(mon_ga), 0);

    // commands to a closed row
    step(0, 1, 0, 0);
    chk("R8", "read to closed refused", int'(mon_gr), 0);
    step(0, 0, 0, 0);
    chk("R8", "error after closed read", int'(mon_er), 1);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R8", "error after closed pre", int'(mon_er), 1);
    step(0, 0, 0, 0);
    chk("R8", "error lasts one cycle", int'(mon_er), 0);

    // flag clear rules
    n_tras = 50;
    idle(1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R3", "flag cleared", int'(clamp_flag), 0);
    n_tras = 0;
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R3", "set wins over clear", int'(clamp_flag), 1);

    // read-limited precharge
    n_trcd = 2; n_tcl = 2; n_trtp = 9; n_tras = 0; n_trrd = 6;
    idle(2);
    run_until(1, 0, 0, 20, t_a);
    idle(9);
    step(0, 1, 0, 0);
    chk("R4", "late read granted", int'(mon_gr), 1);
    run_until(0, 0, 1, 40, t_x);
    chk("R6", "precharge waits trtp after read", t_x - t_a, 19);

    // saturation
    n_trcd = 255; n_tcl = 255; n_trtp = 200; n_tras = 0;
    idle(2);
    chk("R1", "large floor", int'(eff_tras), 710);
    run_until(1, 0, 0, 20, t_a);
    idle(1029);
    step(0, 0, 1, 0);
    chk("R12", "precharge after 1030 cycles", int'(mon_gp), 1);
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule